// File: doc/BRIEF.md
# Byte/Word FIFO Register Port

This block is the register-facing data and status side of a serial flash controller. It holds a transmit byte queue that feeds the shifter and a receive byte queue that the shifter fills. Software reaches both queues through a small register file. One data register per direction always moves a single byte. A second data register per direction moves four bytes per access while the word-mode input is high, and one byte otherwise.

A status register combines two kinds of bit. Sticky event bits (transfer done, receive done, receive data arrived) stay set until software clears them by writing ones. Live bits report queue levels, controller idleness and the current access width. An enable mask selects which of the six low status bits drive the single interrupt output.

Word accesses are all-or-nothing. A word push needs four free entries, and a word pop needs four stored bytes. Otherwise the queue is left untouched.

Top module: `sfrp_top`

## Requirements
- R1: After reset the status register (address 0) reads bits 3 and 4 set, bit 7 equal to ctrl_idle, bit 8 equal to word_mode and all other bits clear. The enable register reads 0, irq is low, tx_valid is low and rx_room is high.
- R2: A write to the TX byte register (address 3) queues reg_wdata[7:0]. Whenever the TX queue holds data, tx_valid is high and tx_byte shows the oldest byte, oldest first. The byte is removed on a clock edge that sees tx_take high.
- R3: A read of the RX byte register (address 2) returns the oldest received byte in bits 7:0 with zeros above it, and removes that one byte.
- R4: With word_mode high, a write to the TX word register (address 5) queues four bytes in the order bits 7:0, 15:8, 23:16, 31:24.
- R5: With word_mode high, a read of the RX word register (address 4) returns the four oldest bytes, the oldest in bits 7:0 and the fourth in bits 31:24, and removes all four.
- R6: With word_mode low, the word registers act like the byte registers: one byte in bits 7:0 per access.
- R7: A TX word write with fewer than four free entries, or a TX byte write to a full queue (16 entries), leaves the TX queue unchanged.
- R8: An RX word read with fewer than four stored bytes, or a byte read from an empty queue, returns 0 and removes nothing.
- R9: Status bit 0 is set by a tx_done_evt pulse and bit 1 by an rx_done_evt pulse. Bit 2 is set when a byte enters an empty RX queue. All three hold until a status write with a 1 in that position; a 0 leaves them. A set in the same cycle beats a clear.
- R10: The live status bits are bit 3 (TX not full), bit 4 (RX empty), bit 5 (TX full), bit 7 (ctrl_idle) and bit 8 (word_mode).
- R11: The enable register (address 1, bits 5:0) reads back as written. irq is high exactly when some status bit 0 to 5 is set with its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_mode | input | 1 | Four-byte access on the word registers |
| ctrl_idle | input | 1 | Controller idle, shown as status bit 7 |
| tx_done_evt | input | 1 | One-cycle pulse: transmit finished |
| rx_done_evt | input | 1 | One-cycle pulse: receive finished |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on RX data registers) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Combined interrupt |
| tx_byte | output | 8 | Oldest TX byte toward the shifter |
| tx_valid | output | 1 | TX queue not empty |
| tx_take | input | 1 | Shifter consumes tx_byte |
| rx_byte | input | 8 | Byte from the shifter |
| rx_push | input | 1 | Shifter delivers rx_byte |
| rx_room | output | 1 | RX queue not full |

## Verification
The properties assume rst_n is low before the first clock and that each register strobe and event pulse is a plain synchronous level seen at one edge. The queue overflow and underflow properties rely on the block's own gating of the shifter handshake and the all-or-nothing word rule. The stimulus therefore changes every input on the falling edge and issues one register access per cycle. It raises tx_take and rx_push only when tx_valid and rx_room allow, even though the block would discard an unsupported request.

// File: rtl/sfrp_pkg.sv
package sfrp_pkg;
  localparam int WORD_BYTES = 4;
  localparam int DATA_W     = 8 * WORD_BYTES;

  localparam logic [2:0] ADR_STAT = 3'd0;
  localparam logic [2:0] ADR_IEN  = 3'd1;
  localparam logic [2:0] ADR_RXB  = 3'd2;
  localparam logic [2:0] ADR_TXB  = 3'd3;
  localparam logic [2:0] ADR_RXW  = 3'd4;
  localparam logic [2:0] ADR_TXW  = 3'd5;

  localparam int NUM_STICKY = 3;
  localparam int NUM_FLAGS  = 6;
endpackage

// File: rtl/sfrp_fifo.sv
module sfrp_fifo #(
  parameter int DEPTH     = 16,
  parameter int LANES     = 4,
  parameter int IN_LANES  = 4,
  parameter int OUT_LANES = 4,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int LVL_W    = $clog2(DEPTH + 1),
  localparam int CNT_W    = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W-1:0]       push_cnt,
  input  logic [IN_LANES*8-1:0]  push_data,
  input  logic [CNT_W-1:0]       pop_cnt,
  output logic [OUT_LANES*8-1:0] peek,
  output logic [LVL_W-1:0]       level
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;

  always_comb begin
    wptr_d = wptr_q + PTR_W'(push_cnt);
    rptr_d = rptr_q + PTR_W'(pop_cnt);
    lvl_d  = lvl_q + LVL_W'(push_cnt) - LVL_W'(pop_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < IN_LANES; i++) begin
      if (CNT_W'(i) < push_cnt) mem[wptr_q + PTR_W'(i)] <= push_data[i*8 +: 8];
    end
  end

  for (genvar g = 0; g < OUT_LANES; g++) begin : g_peek
    assign peek[g*8 +: 8] = mem[rptr_q + PTR_W'(g)];
  end

  assign level = lvl_q;

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(lvl_q) + 32'(push_cnt)) <= (32'(DEPTH) + 32'(pop_cnt)));
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pop_cnt) <= 32'(lvl_q));
endmodule

// File: rtl/sfrp_status.sv
module sfrp_status
  import sfrp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STICKY-1:0] set_evt,
  input  logic                  clr_we,
  input  logic [NUM_STICKY-1:0] clr_mask,
  input  logic                  ien_we,
  input  logic [NUM_FLAGS-1:0]  ien_wdata,
  input  logic                  tx_avail,
  input  logic                  rx_empty,
  input  logic                  tx_full,
  output logic [NUM_FLAGS-1:0]  flags,
  output logic [NUM_FLAGS-1:0]  ien,
  output logic                  irq
);
  logic [NUM_STICKY-1:0] sticky_q, sticky_d;
  logic [NUM_FLAGS-1:0]  ien_q, ien_d;

  always_comb begin
    sticky_d = sticky_q;
    if (clr_we) sticky_d = sticky_d & ~clr_mask;
    sticky_d = sticky_d | set_evt;
    ien_d    = ien_we ? ien_wdata : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      ien_q    <= '0;
    end else begin
      sticky_q <= sticky_d;
      ien_q    <= ien_d;
    end
  end

  assign flags = {tx_full, rx_empty, tx_avail, sticky_q};
  assign ien   = ien_q;
  assign irq   = |(flags & ien_q);

  for (genvar g = 0; g < NUM_STICKY; g++) begin : g_chk
    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_q[g] && !(clr_we && clr_mask[g])) |=> sticky_q[g]);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[g] |=> sticky_q[g]);
  end
endmodule

// File: rtl/sfrp_top.sv
module sfrp_top
  import sfrp_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode,
  input  logic              ctrl_idle,
  input  logic              tx_done_evt,
  input  logic              rx_done_evt,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  input  logic              tx_take,
  input  logic [7:0]        rx_byte,
  input  logic              rx_push,
  output logic              rx_room
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int CNT_W = $clog2(WORD_BYTES + 1);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] LVL_WORD = LVL_W'(WORD_BYTES);
  localparam logic [LVL_W-1:0] LVL_WFREE = LVL_W'(DEPTH - WORD_BYTES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [LVL_W-1:0]  tx_lvl, rx_lvl;
  logic [CNT_W-1:0]  tx_push_cnt, tx_pop_cnt, rx_push_cnt, rx_pop_cnt;
  logic [DATA_W-1:0] rx_peek;
  logic              wr_tx_byte, wr_tx_word, rd_rx_byte, rd_rx_word;
  logic              rx_empty, tx_full, rx_push_ok;
  logic [NUM_FLAGS-1:0] flags, ien;

  // access decode
  always_comb begin
    wr_tx_word = reg_wr && (reg_addr == ADR_TXW) && word_mode;
    wr_tx_byte = reg_wr && ((reg_addr == ADR_TXB) ||
                            ((reg_addr == ADR_TXW) && !word_mode));
    rd_rx_word = reg_rd && (reg_addr == ADR_RXW) && word_mode;
    rd_rx_byte = reg_rd && ((reg_addr == ADR_RXB) ||
                            ((reg_addr == ADR_RXW) && !word_mode));
  end

  // transfer counts, all-or-nothing for word accesses
  always_comb begin
    rx_empty = (rx_lvl == '0);
    tx_full  = (tx_lvl == LVL_FULL);
    if (wr_tx_word && (tx_lvl <= LVL_WFREE)) tx_push_cnt = CNT_W'(WORD_BYTES);
    else if (wr_tx_byte && !tx_full)         tx_push_cnt = CNT_W'(1);
    else                                     tx_push_cnt = '0;
    if (rd_rx_word && (rx_lvl >= LVL_WORD))  rx_pop_cnt = CNT_W'(WORD_BYTES);
    else if (rd_rx_byte && !rx_empty)        rx_pop_cnt = CNT_W'(1);
    else                                     rx_pop_cnt = '0;
    tx_pop_cnt  = (tx_take && (tx_lvl != '0)) ? CNT_W'(1) : '0;
    rx_push_ok  = rx_push && (rx_lvl != LVL_FULL);
    rx_push_cnt = rx_push_ok ? CNT_W'(1) : '0;
  end

  sfrp_fifo #(
    .DEPTH(DEPTH), .LANES(WORD_BYTES), .IN_LANES(WORD_BYTES), .OUT_LANES(1)
  ) u_txq (
    .clk(clk), .rst_n(rst_int_n),
    .push_cnt(tx_push_cnt), .push_data(reg_wdata),
    .pop_cnt(tx_pop_cnt), .peek(tx_byte), .level(tx_lvl)
  );

  sfrp_fifo #(
    .DEPTH(DEPTH), .LANES(WORD_BYTES), .IN_LANES(1), .OUT_LANES(WORD_BYTES)
  ) u_rxq (
    .clk(clk), .rst_n(rst_int_n),
    .push_cnt(rx_push_cnt), .push_data(rx_byte),
    .pop_cnt(rx_pop_cnt), .peek(rx_peek), .level(rx_lvl)
  );

  sfrp_status u_stat (
    .clk(clk), .rst_n(rst_int_n),
    .set_evt({rx_push_ok && rx_empty, rx_done_evt, tx_done_evt}),
    .clr_we(reg_wr && (reg_addr == ADR_STAT)),
    .clr_mask(reg_wdata[NUM_STICKY-1:0]),
    .ien_we(reg_wr && (reg_addr == ADR_IEN)),
    .ien_wdata(reg_wdata[NUM_FLAGS-1:0]),
    .tx_avail(!tx_full), .rx_empty(rx_empty), .tx_full(tx_full),
    .flags(flags), .ien(ien), .irq(irq)
  );

  // read data
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_STAT: reg_rdata = {23'd0, word_mode, ctrl_idle, 1'b0, flags};
      ADR_IEN:  reg_rdata = {26'd0, ien};
      ADR_RXB:  if (!rx_empty) reg_rdata = {24'd0, rx_peek[7:0]};
      ADR_RXW: begin
        if (word_mode) begin
          if (rx_lvl >= LVL_WORD) reg_rdata = rx_peek;
        end else if (!rx_empty) begin
          reg_rdata = {24'd0, rx_peek[7:0]};
        end
      end
      default: reg_rdata = '0;
    endcase
  end

  assign tx_valid = (tx_lvl != '0);
  assign rx_room  = !(rx_lvl == LVL_FULL);

  a_r2_valid_after_push: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_push_cnt != '0) |=> tx_valid);
  a_r8_rx_pop_gated: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_pop_cnt != '0) |-> !rx_empty);
endmodule

// File: tb/sfrp_top_tb.sv
module sfrp_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_mode = 1'b0, ctrl_idle = 1'b1;
  logic        tx_done_evt = 1'b0, rx_done_evt = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq, tx_valid, tx_take = 1'b0, rx_push = 1'b0, rx_room;
  logic [7:0]  tx_byte, rx_byte = 8'd0;
  int          vectors = 0, miscompares = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  sfrp_top u_dut (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .ctrl_idle(ctrl_idle),
    .tx_done_evt(tx_done_evt), .rx_done_evt(rx_done_evt),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_take(tx_take),
    .rx_byte(rx_byte), .rx_push(rx_push), .rx_room(rx_room)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic feed(input logic [7:0] b);
    rx_byte = b; rx_push = 1'b1;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic drain(input string req, input logic [7:0] exp);
    chk({req, " tx_valid"}, {31'd0, tx_valid}, 32'd1);
    chk({req, " tx_byte"}, {24'd0, tx_byte}, {24'd0, exp});
    tx_take = 1'b1;
    @(negedge clk);
    tx_take = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); chk("R1 status", d, 32'h98);
    rd(3'd1, d); chk("R1 ien", d, 32'h0);
    chk("R1 irq/tx_valid/rx_room", {29'd0, irq, tx_valid, rx_room}, 32'd1);
  endtask

  task automatic t_byte_tx;
    wr(3'd3, 32'hFFFF_FFA1); wr(3'd3, 32'h0000_00B2); wr(3'd3, 32'h0000_00C3);
    drain("R2", 8'hA1); drain("R2", 8'hB2); drain("R2", 8'hC3);
    chk("R2 empty after drain", {31'd0, tx_valid}, 32'd0);
  endtask

  task automatic t_byte_rx;
    logic [31:0] d;
    feed(8'h11); feed(8'h22);
    rd(3'd2, d); chk("R3 first", d, 32'h11);
    rd(3'd2, d); chk("R3 second", d, 32'h22);
    rd(3'd2, d); chk("R8 empty byte read", d, 32'h0);
    rd(3'd0, d); chk("R10 rx empty", d & 32'h10, 32'h10);
  endtask

  task automatic t_word_tx;
    word_mode = 1'b1; @(negedge clk);
    wr(3'd5, 32'h4433_2211);
    drain("R4", 8'h11); drain("R4", 8'h22); drain("R4", 8'h33); drain("R4", 8'h44);
    chk("R4 one word only", {31'd0, tx_valid}, 32'd0);
  endtask

  task automatic t_word_rx;
    logic [31:0] d;
    feed(8'hAA); feed(8'hBB); feed(8'hCC); feed(8'hDD); feed(8'hEE);
    rd(3'd4, d); chk("R5 word", d, 32'hDDCC_BBAA);
    rd(3'd2, d); chk("R5 popped four", d, 32'hEE);
  endtask

  task automatic t_word_short;
    logic [31:0] d;
    feed(8'h01); feed(8'h02); feed(8'h03);
    rd(3'd4, d); chk("R8 short word read", d, 32'h0);
    rd(3'd2, d); chk("R8 nothing popped", d, 32'h01);
    rd(3'd2, d); chk("R8 order kept", d, 32'h02);
    rd(3'd2, d); chk("R8 order kept", d, 32'h03);
  endtask

  task automatic t_word_off;
    logic [31:0] d;
    word_mode = 1'b0; @(negedge clk);
    wr(3'd5, 32'h1234_5678);
    drain("R6 tx", 8'h78);
    chk("R6 single byte queued", {31'd0, tx_valid}, 32'd0);
    feed(8'h5A); feed(8'h6B);
    rd(3'd4, d); chk("R6 rx first", d, 32'h5A);
    rd(3'd4, d); chk("R6 rx second", d, 32'h6B);
  endtask

  task automatic t_tx_full;
    logic [31:0] d;
    word_mode = 1'b1; @(negedge clk);
    for (int i = 0; i < 13; i++) wr(3'd3, 32'(8'h40 + 8'(i)));
    wr(3'd5, 32'hAABB_CCDD);
    rd(3'd0, d); chk("R7 word refused, not full", d & 32'h28, 32'h08);
    for (int i = 0; i < 3; i++) wr(3'd3, 32'(8'h60 + 8'(i)));
    rd(3'd0, d); chk("R10 tx full", d & 32'h28, 32'h20);
    wr(3'd3, 32'hEE);
    for (int i = 0; i < 13; i++) drain("R7", 8'h40 + 8'(i));
    for (int i = 0; i < 3; i++) drain("R7", 8'h60 + 8'(i));
    chk("R7 extra byte dropped", {31'd0, tx_valid}, 32'd0);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    wr(3'd0, 32'h7);
    rd(3'd0, d); chk("R9 cleared", d & 32'h7, 32'h0);
    tx_done_evt = 1'b1; @(negedge clk); tx_done_evt = 1'b0;
    rd(3'd0, d); chk("R9 tx done set", d & 32'h7, 32'h1);
    wr(3'd0, 32'h6);
    rd(3'd0, d); chk("R9 zero keeps", d & 32'h7, 32'h1);
    wr(3'd0, 32'h1);
    rd(3'd0, d); chk("R9 one clears", d & 32'h7, 32'h0);
    rx_done_evt = 1'b1; @(negedge clk); rx_done_evt = 1'b0;
    rd(3'd0, d); chk("R9 rx done set", d & 32'h7, 32'h2);
    feed(8'h77);
    rd(3'd2, d); chk("R3 byte", d, 32'h77);
    rd(3'd0, d); chk("R9 rx avail held", d & 32'h7, 32'h6);
    wr(3'd0, 32'h6);
    rd(3'd0, d); chk("R9 both cleared", d & 32'h7, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(3'd1, 32'h1);
    rd(3'd1, d); chk("R11 ien readback", d, 32'h1);
    chk("R11 irq idle", {31'd0, irq}, 32'd0);
    tx_done_evt = 1'b1; @(negedge clk); tx_done_evt = 1'b0;
    chk("R11 irq on tx done", {31'd0, irq}, 32'd1);
    wr(3'd0, 32'h1);
    chk("R11 irq cleared", {31'd0, irq}, 32'd0);
    wr(3'd1, 32'h10);
    chk("R11 irq on rx empty", {31'd0, irq}, 32'd1);
    wr(3'd1, 32'h0);
    chk("R11 irq masked", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_live;
    logic [31:0] d;
    ctrl_idle = 1'b0; word_mode = 1'b1; @(negedge clk);
    rd(3'd0, d); chk("R10 ready low, word flag", d & 32'h180, 32'h100);
    ctrl_idle = 1'b1; word_mode = 1'b0; @(negedge clk);
    rd(3'd0, d); chk("R10 ready high", d & 32'h180, 32'h080);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset(); t_byte_tx(); t_byte_rx(); t_word_tx(); t_word_rx();
    t_word_short(); t_word_off(); t_tx_full(); t_sticky(); t_irq(); t_live();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule